// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory DMA Controller

This block moves data words from one I/O peripheral into memory without the processor handling them. When the peripheral raises its request and the channel is not masked, the controller asks the processor for the buses with a hold request. It waits for the hold acknowledge before it does anything on the bus. It then runs a three-cycle transfer. In the first cycle it drives the memory address and acknowledges the peripheral. In the second cycle it pulls the memory-write and I/O-read strobes low together, so the peripheral puts its word on the data bus and memory captures it in the same cycle. In the third cycle it releases the strobes and advances its address and count.

Software loads a start address and a transfer count through a load strobe while the channel is idle. While the request stays active and the count lasts, the controller chains transfers. On the last transfer it pulses a terminal-count flag and masks itself until it is loaded again. If the processor withdraws hold acknowledge during a transfer, that transfer still completes before the buses are released.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: While `chan_mask` is 1, `dev_req` has no effect: `hold_req` stays 0.
- R2: With `chan_mask` 0, a nonzero remaining count, the channel not self-masked and `dev_req` 1, `hold_req` goes to 1 one clock later. It stays 1 until the controller returns to idle.
- R3: Neither `dev_ack` nor `bus_drive_en` is asserted while the grant is pending. The first transfer cycle begins on the clock after `hold_ack` is seen high with `hold_req` asserted.
- R4: A transfer takes three cycles. In cycle 1, `dev_ack` is 1, `mem_addr` shows the current address, and both strobes are 1. In cycle 2, `mem_wr_n` and `io_rd_n` are both 0 and `dev_ack` is 1. In cycle 3, both strobes are 1 and `dev_ack` is 0. Outside these three cycles, `mem_addr` reads 0.
- R5: Each completed transfer increments the address by one, wrapping modulo 2^ADDR_W, and decrements the remaining count by one.
- R6: After cycle 3, the controller goes straight back to the hold-request state if all of these hold: `hold_ack` is 1, `dev_req` is 1, `chan_mask` is 0, and transfers remain. Otherwise it returns to idle with `hold_req` at 0 for at least one clock.
- R7: `term_cnt` is 1 for exactly the third cycle of the transfer that brings the count to zero. After that the channel is self-masked, and requests are ignored until the next load.
- R8: `bus_drive_en` is 1 exactly when the controller is in a transfer cycle and `hold_ack` is 1.
- R9: If `hold_ack` falls during a transfer, cycles 2 and 3 still occur with their strobes, and the controller then returns to idle.
- R10: A `cfg_load` pulse in idle loads `start_addr` and `xfer_count` and clears the self-mask. A `cfg_load` pulse in any other state is ignored.
- R11: With a remaining count of zero, requests are ignored.
- R12: If the request is no longer valid while the grant is pending and `hold_ack` is 0, the controller drops `hold_req` and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_req | input | 1 | Peripheral transfer request |
| chan_mask | input | 1 | Channel mask, 1 blocks requests |
| hold_ack | input | 1 | Processor bus grant |
| cfg_load | input | 1 | Load strobe for address and count |
| start_addr | input | ADDR_W | Programmed start address |
| xfer_count | input | CNT_W | Programmed number of transfers |
| hold_req | output | 1 | Bus request to the processor |
| dev_ack | output | 1 | Peripheral acknowledge |
| mem_addr | output | ADDR_W | Memory address during a transfer, else 0 |
| bus_drive_en | output | 1 | Enables the controller's bus drivers |
| mem_wr_n | output | 1 | Active-low memory write strobe |
| io_rd_n | output | 1 | Active-low I/O read strobe |
| term_cnt | output | 1 | One-cycle terminal-count pulse |

## Verification
The bench holds the grant back for several cycles. A design that jumped ahead of `hold_ack` would show `dev_ack` or an address early. It runs a chained burst to terminal count and then keeps requesting, which exposes an off-by-one count, a `term_cnt` pulse in the wrong cycle, or a missing self-mask that would restart the channel. It also drops `hold_ack` inside a transfer: a design that aborted would skip the strobe cycle, and one that ignored the drop would chain on without the buses. Finally it covers an address wrap at the top of the range, a load attempted mid-burst, and a zero count. Errors there would show up as a wrong address, a stretched burst, or a spurious hold request.

// File: rtl/dma_pkg.sv
// Shared types for the single-channel DMA controller.
// Assumes: one channel, peripheral-to-memory direction only.
package dma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // no bus activity
        ST_REQ  = 3'd1,  // hold request raised, waiting for grant
        ST_S1   = 3'd2,  // address driven, peripheral acknowledged
        ST_S2   = 3'd3,  // write and read strobes low
        ST_S3   = 3'd4   // strobes released, counters advance
    } xfer_state_t;
endpackage

// File: rtl/dma_ptr.sv
// Address, remaining-count and self-mask registers of the channel.
// Assumes: load_en is only raised in idle, so it never coincides with step.
module dma_ptr #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CNT_W-1:0]  load_cnt,
    input  logic              step,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              last_xfer,
    output logic              cnt_empty,
    output logic              self_mask
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] remain;

    // Address register: loaded by software, advanced after each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)       cur_addr <= '0;
        else if (load_en) cur_addr <= load_addr;
        else if (step)    cur_addr <= cur_addr + 1'b1;
    end

    // Remaining-transfer counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       remain <= '0;
        else if (load_en) remain <= load_cnt;
        else if (step)    remain <= remain - 1'b1;
    end

    // Self-mask: set by the final transfer, cleared by a new load.
    always_ff @(posedge clk) begin
        if (!rst_n)                  self_mask <= 1'b0;
        else if (load_en)            self_mask <= 1'b0;
        else if (step && last_xfer)  self_mask <= 1'b1;
    end

    // Count status decode.
    always_comb begin
        last_xfer = (remain == CNT_ONE);
        cnt_empty = (remain == '0);
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> cur_addr == ADDR_W'($past(cur_addr) + 1'b1)); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> remain == CNT_W'($past(remain) - 1'b1)); // R5
    AST_SELF_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last_xfer) |=> self_mask); // R7
endmodule

// File: rtl/dma_seq.sv
// Transfer sequencer: request/grant handshake and the three transfer cycles.
// Assumes: hold_ack is synchronous to clk.
module dma_seq
    import dma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dev_req,
    input  logic        chan_mask,
    input  logic        self_mask,
    input  logic        cnt_empty,
    input  logic        last_xfer,
    input  logic        hold_ack,
    output xfer_state_t state
);
    xfer_state_t nxt;
    logic        go;

    // A request is eligible only when unmasked and transfers remain.
    always_comb go = dev_req && !chan_mask && !self_mask && !cnt_empty;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (go) nxt = ST_REQ;
            ST_REQ: begin
                if (hold_ack) nxt = ST_S1;
                else if (!go) nxt = ST_IDLE;
            end
            ST_S1: nxt = ST_S2;
            ST_S2: nxt = ST_S3;
            ST_S3: begin
                if (hold_ack && dev_req && !chan_mask && !last_xfer) nxt = ST_REQ;
                else                                                  nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    AST_IDLE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !go) |=> state == ST_IDLE); // R1
    AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQ && !hold_ack) |=> state != ST_S1); // R3
    AST_S1_TO_S2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S1) |=> state == ST_S2); // R9
    AST_S2_TO_S3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S2) |=> state == ST_S3); // R9
    AST_S3_NOGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S3 && !hold_ack) |=> state == ST_IDLE); // R9
endmodule

// File: rtl/dma_drive.sv
// Bus-side output decode from the sequencer state.
// Assumes: outputs are decoded combinationally and registered downstream if needed.
module dma_drive
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  xfer_state_t       state,
    input  logic              hold_ack,
    input  logic              last_xfer,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic              hold_req,
    output logic              dev_ack,
    output logic              bus_drive_en,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              term_cnt,
    output logic [ADDR_W-1:0] mem_addr
);
    logic in_xfer;

    // Per-state output decode.
    always_comb begin
        in_xfer      = (state == ST_S1) || (state == ST_S2) || (state == ST_S3);
        hold_req     = (state != ST_IDLE);
        dev_ack      = (state == ST_S1) || (state == ST_S2);
        bus_drive_en = in_xfer && hold_ack;
        mem_wr_n     = (state != ST_S2);
        io_rd_n      = (state != ST_S2);
        term_cnt     = (state == ST_S3) && last_xfer;
        mem_addr     = in_xfer ? cur_addr : '0;
    end

    AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> (!io_rd_n && dev_ack)); // R4
    AST_BUS_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive_en |-> hold_ack); // R8
    AST_ACK_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> hold_req); // R3
    AST_TC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt |=> !term_cnt); // R7
endmodule

// File: rtl/dma_xfer_ctrl.sv
// Single-channel peripheral-to-memory DMA controller top level.
// Assumes: configuration is loaded only while idle; one word per transfer.
module dma_xfer_ctrl
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_req,
    input  logic              chan_mask,
    input  logic              hold_ack,
    input  logic              cfg_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  xfer_count,
    output logic              hold_req,
    output logic              dev_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              bus_drive_en,
    output logic              mem_wr_n,
    output logic              io_rd_n,
    output logic              term_cnt
);
    xfer_state_t      state;
    logic             load_en;
    logic             step;
    logic [ADDR_W-1:0] cur_addr;
    logic             last_xfer;
    logic             cnt_empty;
    logic             self_mask;

    // Load only in idle; advance counters in the release cycle.
    always_comb begin
        load_en = cfg_load && (state == ST_IDLE);
        step    = (state == ST_S3);
    end

    dma_ptr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_addr (start_addr),
        .load_cnt  (xfer_count),
        .step      (step),
        .cur_addr  (cur_addr),
        .last_xfer (last_xfer),
        .cnt_empty (cnt_empty),
        .self_mask (self_mask)
    );

    dma_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_req   (dev_req),
        .chan_mask (chan_mask),
        .self_mask (self_mask),
        .cnt_empty (cnt_empty),
        .last_xfer (last_xfer),
        .hold_ack  (hold_ack),
        .state     (state)
    );

    dma_drive #(.ADDR_W(ADDR_W)) u_drive (
        .clk          (clk),
        .rst_n        (rst_n),
        .state        (state),
        .hold_ack     (hold_ack),
        .last_xfer    (last_xfer),
        .cur_addr     (cur_addr),
        .hold_req     (hold_req),
        .dev_ack      (dev_ack),
        .bus_drive_en (bus_drive_en),
        .mem_wr_n     (mem_wr_n),
        .io_rd_n      (io_rd_n),
        .term_cnt     (term_cnt),
        .mem_addr     (mem_addr)
    );

    AST_LOAD_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && state != ST_IDLE) |=> $stable(self_mask) || state == ST_IDLE); // R10
endmodule

// File: tb/dma_xfer_ctrl_tb.sv
// Directed bench for dma_xfer_ctrl; inputs change and outputs are sampled at negedge.
module dma_xfer_ctrl_tb;
    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dev_req = 1'b0, chan_mask = 1'b0, hold_ack = 1'b0, cfg_load = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] xfer_count = '0;
    logic          hold_req, dev_ack, bus_drive_en, mem_wr_n, io_rd_n, term_cnt;
    logic [AW-1:0] mem_addr;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dma_xfer_ctrl #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .chan_mask(chan_mask),
        .hold_ack(hold_ack), .cfg_load(cfg_load), .start_addr(start_addr),
        .xfer_count(xfer_count), .hold_req(hold_req), .dev_ack(dev_ack),
        .mem_addr(mem_addr), .bus_drive_en(bus_drive_en), .mem_wr_n(mem_wr_n),
        .io_rd_n(io_rd_n), .term_cnt(term_cnt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_cfg(input logic [AW-1:0] a, input logic [CW-1:0] c);
        dev_req = 1'b0;
        start_addr = a;
        xfer_count = c;
        cfg_load = 1'b1;
        tick();
        cfg_load = 1'b0;
    endtask

    // Called in the grant-pending state with hold_ack high; runs S1..S3.
    task automatic do_xfer(input logic [AW-1:0] exp_addr, input logic exp_tc);
        tick();
        chk("R4 S1 dev_ack", dev_ack, 1);
        chk("R4 S1 mem_addr", mem_addr, exp_addr);
        chk("R4 S1 strobes", {mem_wr_n, io_rd_n}, 2'b11);
        chk("R8 S1 bus_drive_en", bus_drive_en, 1);
        tick();
        chk("R4 S2 strobes low", {mem_wr_n, io_rd_n}, 2'b00);
        chk("R4 S2 dev_ack", dev_ack, 1);
        tick();
        chk("R4 S3 strobes high", {mem_wr_n, io_rd_n}, 2'b11);
        chk("R4 S3 dev_ack", dev_ack, 0);
        chk("R7 term_cnt", term_cnt, exp_tc);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R2 reset hold_req", hold_req, 0);
        chk("R4 reset strobes", {mem_wr_n, io_rd_n, dev_ack}, 3'b110);
        chk("R8 reset bus_drive_en", bus_drive_en, 0);
        chk("R7 reset term_cnt", term_cnt, 0);
        chk("R4 reset mem_addr", mem_addr, 0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_masked();
        load_cfg(16'h0100, 8'd3);
        chan_mask = 1'b1;
        dev_req = 1'b1;
        repeat (4) tick();
        chk("R1 masked hold_req", hold_req, 0);
        chk("R1 masked dev_ack", dev_ack, 0);
    endtask

    task automatic t_burst_to_tc();
        hold_ack = 1'b0;
        chan_mask = 1'b0;
        tick();
        chk("R2 hold_req raised", hold_req, 1);
        chk("R3 no ack before grant", dev_ack, 0);
        chk("R3 no bus drive before grant", bus_drive_en, 0);
        repeat (3) tick();
        chk("R3 still waiting", {hold_req, dev_ack}, 2'b10);
        chk("R4 no addr outside xfer", mem_addr, 0);
        hold_ack = 1'b1;
        do_xfer(16'h0100, 1'b0);
        tick();
        chk("R6 chained to request", hold_req, 1);
        chk("R4 addr idle between", mem_addr, 0);
        do_xfer(16'h0101, 1'b0);  // R5 address step
        tick();
        do_xfer(16'h0102, 1'b1);
        tick();
        chk("R7 hold dropped after tc", hold_req, 0);
        chk("R7 term_cnt single", term_cnt, 0);
        repeat (3) tick();
        chk("R7 self-masked", hold_req, 0);
    endtask

    task automatic t_load_ignored();
        load_cfg(16'h0200, 8'd2);
        dev_req = 1'b1;
        tick();
        chk("R10 load cleared self mask", hold_req, 1);
        start_addr = 16'h0300;
        xfer_count = 8'd9;
        cfg_load = 1'b1;
        do_xfer(16'h0200, 1'b0);
        cfg_load = 1'b0;
        tick();
        do_xfer(16'h0201, 1'b1);  // R10 mid-burst load had no effect
        tick();
        chk("R10 burst ended", hold_req, 0);
    endtask

    task automatic t_req_drop();
        load_cfg(16'h0400, 8'd5);
        dev_req = 1'b1;
        tick();
        dev_req = 1'b0;
        do_xfer(16'h0400, 1'b0);
        tick();
        chk("R6 idle after req drop", hold_req, 0);
        tick();
        chk("R6 stays idle", hold_req, 0);
    endtask

    task automatic t_ack_drop();
        dev_req = 1'b1;
        tick();
        tick();
        chk("R9 S1 addr", mem_addr, 16'h0401);
        hold_ack = 1'b0;
        tick();
        chk("R9 S2 strobes still low", {mem_wr_n, io_rd_n}, 2'b00);
        chk("R8 no drive without grant", bus_drive_en, 0);
        tick();
        chk("R9 S3 released", {mem_wr_n, io_rd_n}, 2'b11);
        tick();
        chk("R9 back to idle", hold_req, 0);
        tick();
        chk("R2 re-request", hold_req, 1);
        dev_req = 1'b0;
        tick();
        chk("R12 withdrawn before grant", hold_req, 0);
    endtask

    task automatic t_zero_count();
        load_cfg(16'h0010, 8'd0);
        dev_req = 1'b1;
        hold_ack = 1'b1;
        repeat (3) tick();
        chk("R11 zero count ignored", hold_req, 0);
    endtask

    task automatic t_wrap();
        load_cfg(16'hFFFF, 8'd2);
        dev_req = 1'b1;
        tick();
        do_xfer(16'hFFFF, 1'b0);
        tick();
        do_xfer(16'h0000, 1'b1);  // R5 wrap
        dev_req = 1'b0;
        tick();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_masked();
        t_burst_to_tc();
        t_load_ignored();
        t_req_drop();
        t_ack_drop();
        t_zero_count();
        t_wrap();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule